// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address by reading a radix tree of translation tables held in memory. A request carries the virtual address and the root register value. The walker first checks that the address is canonical. It then reads one 8-byte entry per level, from the top level down. The walk ends with a physical address for a 4 KB, 2 MB or 1 GB page, or with a fault code and the level at which it stopped.

The request side is a valid/ready stream. `req_ready` is high only while the walker is idle, so a requester holds `req_valid` and its payload until the two meet at a clock edge. The memory side issues one read at a time. `mem_req_valid` and `mem_req_addr` stay stable until `mem_req_ready` accepts them. The walker then waits for a single `mem_rsp_valid` beat and raises no new read before that beat. It has no ready on the response side, because it can always take the one beat it is waiting for. The result comes back as a one-cycle pulse on `res_valid` with no back-pressure, so the consumer must capture it in that cycle.

Top module: `pt_walker`

## Requirements
- R1: A virtual address whose bits 63..47 are not all equal ends the walk with `res_fault` = 1 (non-canonical) and `res_level` = 3, and no memory read is made.
- R2: The first read address is (root AND 0x000F_FFFF_FFFF_F000) + 8 × VA[47:39]. Root bits 11..0 and 63..52 have no effect on the walk.
- R3: The next table base is (entry AND 0x000F_FFFF_FFFF_F000). The indices for the following levels are VA[38:30], VA[29:21] and VA[20:12], each scaled by 8.
- R4: An entry with bit 0 = 0 ends the walk at once with `res_fault` = 2 and `res_level` giving the level. The level codes are 3 for the top level down to 0 for the last level. No further read is made.
- R5: At the third level from the bottom (level code 2), a present entry with bit 7 set ends the walk after 2 reads. The result is `res_size` = 2 and PA = (entry AND 0x000F_FFFF_C000_0000) + VA[29:0].
- R6: At level code 1, a present entry with bit 7 set ends the walk after 3 reads. The result is `res_size` = 1 and PA = (entry AND 0x000F_FFFF_FFE0_0000) + VA[20:0].
- R7: A walk that reaches level code 0 makes exactly 4 reads. The result is `res_size` = 0 and PA = (entry AND 0x000F_FFFF_FFFF_F000) + VA[11:0].
- R8: Bit 7 is ignored at level codes 3 and 0. It never ends a walk early there and never changes the result.
- R9: `req_ready` is high only when idle. One walk runs at a time, and a request is taken only on a `req_valid`/`req_ready` edge.
- R10: `res_valid` is high for exactly one cycle per walk. On success `res_fault` = 0. On a fault `res_paddr` = 0 and `res_size` = 0.
- R11: At most one memory read is outstanding. `mem_req_valid` and `mem_req_addr` hold stable until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 64 | Virtual address to translate |
| req_root | input | 64 | Root register value |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts read |
| mem_req_addr | output | 64 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read data beat valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| res_valid | output | 1 | One-cycle result pulse |
| res_paddr | output | 64 | Translated physical address |
| res_fault | output | 2 | 0 none, 1 non-canonical, 2 not present |
| res_level | output | 2 | Level of the fault, 3 (top) .. 0 (last) |
| res_size | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |

## Verification
Directed walks cover several cases. Plain 4 KB, 2 MB and 1 GB walks separate the three leaf depths by their read counts and offset masks. Bit 7 set at the top and last levels shows that large-page exit is limited to the two middle levels. A missing entry at each of the four levels tells the level codes apart. Addresses just inside and just outside the canonical range test the pre-check. Root and entry values with junk in their low flag bits and high bits show that only the frame bits steer the walk. Seeded random trees mix all of these with random memory stalls, so that handshake timing cannot alter a result.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_FETCH_L4, S_FETCH_L3, S_FETCH_L2, S_FETCH_L1, S_DONE, S_FAULT
  } walk_state_t;

  localparam logic [1:0] FLT_NONE     = 2'd0;
  localparam logic [1:0] FLT_NONCANON = 2'd1;
  localparam logic [1:0] FLT_ABSENT   = 2'd2;

  localparam int PRESENT_BIT = 0;
  localparam int LARGE_BIT   = 7;
endpackage

// File: rtl/pt_canon_check.sv
module pt_canon_check #(
  parameter int ADDR_W = 64,
  parameter int TOP_LO = 47
) (
  input  logic [ADDR_W-1:0] vaddr,
  output logic              canon_ok
);
  logic [ADDR_W-1-TOP_LO:0] upper;
  assign upper    = vaddr[ADDR_W-1:TOP_LO];
  assign canon_ok = (&upper) | ~(|upper);
endmodule

// File: rtl/pt_index_sel.sv
module pt_index_sel #(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LEVELS = 4,
  parameter int ENT_LG = 3,
  parameter int LVL_W  = 2
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [LVL_W-1:0]  level,
  output logic [ADDR_W-1:0] entry_addr
);
  logic [IDX_W-1:0] idx_arr [LEVELS];

  generate
    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
      assign idx_arr[g] = vaddr[OFF_W + g*IDX_W +: IDX_W];
    end
  endgenerate

  assign entry_addr = tbl_base + (ADDR_W'(idx_arr[level]) << ENT_LG);
endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int PA_HI  = 51,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LEVELS = 4,
  parameter int LVL_W  = 2
) (
  input  logic [ADDR_W-1:0] entry,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [LVL_W-1:0]  level,
  output logic              present,
  output logic              leaf,
  output logic [ADDR_W-1:0] next_base,
  output logic [ADDR_W-1:0] leaf_paddr,
  output logic [1:0]        leaf_size
);
  localparam logic [ADDR_W-1:0] PHYS_M = {ADDR_W{1'b1}} >> (ADDR_W - 1 - PA_HI);

  logic [ADDR_W-1:0] off_m [LEVELS];

  generate
    for (genvar g = 0; g < LEVELS; g++) begin : g_off
      assign off_m[g] = (ADDR_W'(1) << (OFF_W + g*IDX_W)) - ADDR_W'(1);
    end
  endgenerate

  assign present    = entry[PRESENT_BIT];
  assign leaf       = (level == '0) ||
                      (entry[LARGE_BIT] && (level != LVL_W'(LEVELS - 1)));
  assign next_base  = entry & PHYS_M & ~off_m[0];
  assign leaf_paddr = (entry & PHYS_M & ~off_m[level]) | (vaddr & off_m[level]);
  assign leaf_size  = 2'(level);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int PA_HI  = 51,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int ENT_LG = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_vaddr,
  input  logic [63:0] req_root,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [63:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        res_valid,
  output logic [63:0] res_paddr,
  output logic [1:0]  res_fault,
  output logic [1:0]  res_level,
  output logic [1:0]  res_size
);
  localparam int LEVELS = 4;
  localparam int LVL_W  = 2;
  localparam int TOP_LO = OFF_W + LEVELS*IDX_W - 1;
  localparam logic [ADDR_W-1:0] TBL_M =
    ({ADDR_W{1'b1}} >> (ADDR_W - 1 - PA_HI)) & ({ADDR_W{1'b1}} << OFF_W);

  walk_state_t       state_q;
  logic [ADDR_W-1:0] va_q, base_q, paddr_q;
  logic              issued_q;
  logic [1:0]        fault_q, level_q, size_q;
  logic [LVL_W-1:0]  cur_lvl;
  logic              fetching;
  walk_state_t       next_fetch;

  logic              canon_ok;
  logic [ADDR_W-1:0] entry_addr;
  logic              ent_present, ent_leaf;
  logic [ADDR_W-1:0] ent_next, ent_pa;
  logic [1:0]        ent_size;

  always_comb begin
    fetching   = 1'b1;
    cur_lvl    = '0;
    next_fetch = S_FETCH_L1;
    case (state_q)
      S_FETCH_L4: begin cur_lvl = 2'd3; next_fetch = S_FETCH_L3; end
      S_FETCH_L3: begin cur_lvl = 2'd2; next_fetch = S_FETCH_L2; end
      S_FETCH_L2: begin cur_lvl = 2'd1; next_fetch = S_FETCH_L1; end
      S_FETCH_L1: begin cur_lvl = 2'd0; next_fetch = S_FETCH_L1; end
      default:    fetching = 1'b0;
    endcase
  end

  pt_canon_check #(.ADDR_W(ADDR_W), .TOP_LO(TOP_LO)) u_canon (
    .vaddr    (va_q),
    .canon_ok (canon_ok)
  );

  pt_index_sel #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
    .LEVELS(LEVELS), .ENT_LG(ENT_LG), .LVL_W(LVL_W)
  ) u_idx (
    .vaddr      (va_q),
    .tbl_base   (base_q),
    .level      (cur_lvl),
    .entry_addr (entry_addr)
  );

  pt_entry_decode #(
    .ADDR_W(ADDR_W), .PA_HI(PA_HI), .IDX_W(IDX_W), .OFF_W(OFF_W),
    .LEVELS(LEVELS), .LVL_W(LVL_W)
  ) u_dec (
    .entry      (mem_rsp_data),
    .vaddr      (va_q),
    .level      (cur_lvl),
    .present    (ent_present),
    .leaf       (ent_leaf),
    .next_base  (ent_next),
    .leaf_paddr (ent_pa),
    .leaf_size  (ent_size)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      va_q     <= '0;
      base_q   <= '0;
      paddr_q  <= '0;
      issued_q <= 1'b0;
      fault_q  <= FLT_NONE;
      level_q  <= '0;
      size_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            va_q    <= req_vaddr;
            base_q  <= req_root & TBL_M;
            state_q <= S_CHECK;
          end
        end
        S_CHECK: begin
          issued_q <= 1'b0;
          if (!canon_ok) begin
            fault_q <= FLT_NONCANON;
            level_q <= 2'd3;
            paddr_q <= '0;
            size_q  <= '0;
            state_q <= S_FAULT;
          end else begin
            state_q <= S_FETCH_L4;
          end
        end
        S_FETCH_L4, S_FETCH_L3, S_FETCH_L2, S_FETCH_L1: begin
          if (!issued_q) begin
            if (mem_req_ready) issued_q <= 1'b1;
          end else if (mem_rsp_valid) begin
            issued_q <= 1'b0;
            if (!ent_present) begin
              fault_q <= FLT_ABSENT;
              level_q <= cur_lvl;
              paddr_q <= '0;
              size_q  <= '0;
              state_q <= S_FAULT;
            end else if (ent_leaf) begin
              fault_q <= FLT_NONE;
              level_q <= cur_lvl;
              paddr_q <= ent_pa;
              size_q  <= ent_size;
              state_q <= S_DONE;
            end else begin
              base_q  <= ent_next;
              state_q <= next_fetch;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == S_IDLE);
  assign mem_req_valid = fetching && !issued_q;
  assign mem_req_addr  = entry_addr;
  assign res_valid     = (state_q == S_DONE) || (state_q == S_FAULT);
  assign res_paddr     = paddr_q;
  assign res_fault     = fault_q;
  assign res_level     = level_q;
  assign res_size      = size_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [63:0] mem_req_addr,
  input logic        mem_rsp_valid,
  input logic        res_valid,
  input logic [1:0]  res_fault,
  input logic [1:0]  res_size
);
  logic [2:0] reads_q;
  logic       outstanding_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reads_q       <= '0;
      outstanding_q <= 1'b0;
    end else begin
      if (req_valid && req_ready) reads_q <= '0;
      else if (mem_req_valid && mem_req_ready) reads_q <= reads_q + 3'd1;
      if (mem_req_valid && mem_req_ready) outstanding_q <= 1'b1;
      else if (mem_rsp_valid) outstanding_q <= 1'b0;
    end
  end

  a_r1_no_read_on_noncanon: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault == 2'd1 |-> reads_q == 3'd0);
  a_r4_fault_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_fault != 2'd3);
  a_r5_giant_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault == 2'd0 && res_size == 2'd2 |-> reads_q == 3'd2);
  a_r6_large_three_reads: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault == 2'd0 && res_size == 2'd1 |-> reads_q == 3'd3);
  a_r7_small_four_reads: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault == 2'd0 && res_size == 2'd0 |-> reads_q == 3'd4);
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  a_r10_result_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  a_r11_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding_q |-> !mem_req_valid);
  a_r11_request_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .res_valid     (res_valid),
  .res_fault     (res_fault),
  .res_size      (res_size)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [63:0] req_root = '0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        res_valid;
  logic [63:0] res_paddr;
  logic [1:0]  res_fault, res_level, res_size;

  localparam logic [63:0] FRAME4K = 64'h000F_FFFF_FFFF_F000;

  int checks = 0;
  int fails  = 0;
  int reads_seen = 0;
  logic [63:0] mem [logic [63:0]];

  always #10 clk = ~clk;

  pt_walker dut (.*);

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model with random accept and response stalls
  initial begin
    bit pend = 0;
    int dly = 0;
    logic [63:0] pa = '0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd(pa);
          pend = 0;
        end else dly--;
      end
      mem_req_ready = ($urandom % 4) != 0;
      if (mem_req_valid && mem_req_ready) begin
        pend = 1;
        pa   = mem_req_addr;
        dly  = $urandom % 3;
        reads_seen++;
      end
    end
  end

  function automatic void ref_walk(input logic [63:0] va, input logic [63:0] root,
                                   output logic [63:0] pa, output logic [1:0] flt,
                                   output logic [1:0] lvl, output logic [1:0] sz,
                                   output int nrd);
    logic [63:0] base, e, om;
    pa = '0; flt = 2'd0; lvl = 2'd3; sz = 2'd0; nrd = 0;
    if (!(va[63:47] == '0 || va[63:47] == '1)) begin
      flt = 2'd1;
      return;
    end
    base = root & FRAME4K;
    for (int l = 3; l >= 0; l--) begin
      e = rd(base + (((va >> (12 + 9*l)) & 64'h1FF) << 3));
      nrd++;
      if (!e[0]) begin
        flt = 2'd2; lvl = 2'(l);
        return;
      end
      if (l == 0 || ((l == 1 || l == 2) && e[7])) begin
        om  = (64'd1 << (12 + 9*l)) - 64'd1;
        pa  = (e & 64'h000F_FFFF_FFFF_FFFF & ~om) | (va & om);
        sz  = 2'(l);
        lvl = 2'(l);
        return;
      end
      base = e & FRAME4K;
    end
  endfunction

  // build one path; absent_l: level whose entry lacks P (-1 none);
  // large_l: level whose entry gets bit 7; junk adds bits outside the frame
  task automatic build(input logic [63:0] va, input logic [63:0] root,
                       input int absent_l, input int large_l, input bit junk);
    logic [63:0] base, e;
    base = root & FRAME4K;
    for (int l = 3; l >= 0; l--) begin
      e = ({$urandom, $urandom} & FRAME4K);
      if (junk) e = e | ({$urandom, $urandom} & 64'hFFF0_0000_0000_0F7E);
      e[7] = (l == large_l);
      e[0] = (l != absent_l);
      mem[base + (((va >> (12 + 9*l)) & 64'h1FF) << 3)] = e;
      if (l == absent_l) return;
      if ((l == 1 || l == 2) && l == large_l) return;
      base = e & FRAME4K;
    end
  endtask

  task automatic walk(input logic [63:0] va, input logic [63:0] root, input string tag);
    logic [63:0] epa; logic [1:0] ef, el, es; int en;
    logic [63:0] apa; logic [1:0] af, al, as_; int guard;
    bit got;
    ref_walk(va, root, epa, ef, el, es, en);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    reads_seen = 0;
    req_vaddr = va; req_root = root; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got = 0; guard = 0;
    while (!got && guard < 400) begin
      if (res_valid) got = 1;
      else begin @(negedge clk); guard++; end
    end
    chk(got, {tag, " result seen"}, 64'(got), 64'd1);
    if (!got) return;
    apa = res_paddr; af = res_fault; al = res_level; as_ = res_size;
    chk(af == ef, {tag, " fault"}, 64'(af), 64'(ef));
    chk(apa == epa, {tag, " paddr"}, apa, epa);
    chk(as_ == es, {tag, " size"}, 64'(as_), 64'(es));
    if (ef != 2'd0) chk(al == el, {tag, " level"}, 64'(al), 64'(el));
    chk(reads_seen == en, {tag, " R11 reads"}, 64'(reads_seen), 64'(en));
    @(negedge clk);
    chk(!res_valid, {tag, " R10 pulse"}, 64'(res_valid), 64'd0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] va, root;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R9 reset ready", 64'(req_ready), 64'd1);
    chk(res_valid == 1'b0, "R10 reset res_valid", 64'(res_valid), 64'd0);
    chk(mem_req_valid == 1'b0, "R11 reset mem_req_valid", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;

    // R7, R2, R3: 4 KB walk with junk in root and entry low/high bits
    va = 64'h0000_1234_5678_9ABC; root = 64'hFFF0_0000_0040_0FFF;
    mem.delete(); build(va, root, -1, -1, 1); walk(va, root, "R7 4K walk R2 R3");
    // R6: 2 MB leaf
    va = 64'hFFFF_8765_4321_0FED; root = 64'h0000_0000_0080_0000;
    mem.delete(); build(va, root, -1, 1, 1); walk(va, root, "R6 2M walk");
    // R5: 1 GB leaf
    va = 64'h0000_7ABC_DEF0_1234; root = 64'h0000_0012_3456_7000;
    mem.delete(); build(va, root, -1, 2, 1); walk(va, root, "R5 1G walk");
    // R8: bit 7 at the top and last levels is ignored
    va = 64'h0000_0F0F_0F0F_0F0F; root = 64'h0000_0000_0100_0000;
    mem.delete(); build(va, root, -1, 3, 0); walk(va, root, "R8 top bit7");
    mem.delete(); build(va, root, -1, 0, 0); walk(va, root, "R8 last bit7");
    // R4: absent entry at every level
    for (int l = 3; l >= 0; l--) begin
      va = 64'hFFFF_FFFF_FFFE_00B0;
      mem.delete(); build(va, root, l, -1, 1); walk(va, root, "R4 absent");
    end
    // R1: canonical edges
    mem.delete(); build(64'h0000_7FFF_FFFF_FFFF, root, -1, -1, 0);
    walk(64'h0000_7FFF_FFFF_FFFF, root, "R1 top of low half");
    walk(64'h0000_8000_0000_0000, root, "R1 noncanon low");
    walk(64'hFFFF_7FFF_FFFF_FFFF, root, "R1 noncanon high");
    mem.delete(); build(64'hFFFF_8000_0000_0000, root, -1, -1, 0);
    walk(64'hFFFF_8000_0000_0000, root, "R1 bottom of high half");

    // constrained random trees
    for (int n = 0; n < 60; n++) begin
      int ab, lg;
      va = {$urandom, $urandom};
      if (($urandom % 8) != 0) va[63:47] = va[47] ? '1 : '0;
      root = {$urandom, $urandom};
      ab = (($urandom % 4) == 0) ? int'($urandom % 4) : -1;
      lg = int'($urandom % 5) - 1;
      mem.delete(); build(va, root, ab, lg, 1);
      walk(va, root, "R2 R3 R4 R5 R6 R7 R8 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule